// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is a free-running binary counter whose advance is paced by one of several single-cycle tick lines. A 3-bit field in the mode word picks which line paces it; one of those lines is meant to carry the underflow pulse of a prescaler timer. Two compare/capture registers, A and B, serve one of two roles. In compare use they drive a set/reset flip-flop output. In capture mode they snapshot the counter on rising edges of two external capture inputs. A capture on the B channel raises a sticky request flag. That flag reaches the interrupt output through an enable bit and a 3-bit level.

Control runs through a three-state sequencer. **CLEAR** is entered whenever the not-clear bit (mode bit 14) is 0, and there the counter and the flip-flop are forced to zero. **ARMED** is reached from CLEAR once bit 14 is 1, and the count holds there. **RUN** is reached from ARMED once the enable bit (mode bit 15) is 1. RUN falls back to ARMED when enable drops. Both ARMED and RUN return to CLEAR when bit 14 drops. The counter advances only in RUN.

Software writes registers through a simple write port: address 0 is the mode word, 1 is register A, 2 is register B and 3 is the interrupt control word. All register values are visible on dedicated outputs.

Top module: `cap_timer16`

## Requirements
- R1: After reset the mode word, count, A, B, flip-flop output, request flag and interrupt request are all zero.
- R2: While mode bit 14 is 0, the counter and the flip-flop are cleared to zero and ticks have no effect.
- R3: With mode bit 14 set and bit 15 clear, the sequencer is armed and the count holds. Counting needs bit 15 set as well.
- R4: Mode bits [2:0] select which `tick_src` line advances the counter by one per high cycle, with code 1 choosing line 1, the prescaler underflow input. Pulses on unselected lines are ignored.
- R5: Counting up with bit 6 clear, the counter rolls over from 0xFFFF to 0x0000 and keeps counting.
- R6: Writes to A (address 1) and B (address 2) take effect only when mode bits [9:8] are 2'b00. They are ignored when those bits are 2'b11 (capture mode).
- R7: One cycle after the count equals A, the flip-flop output goes to 1. One cycle after the count equals B, it goes to 0, and reset wins if both match.
- R8: In capture mode, a rising edge on `cap_a_in` or `cap_b_in` passes through a two-flop synchronizer and latches the count into A or B respectively. Outside capture mode, edges latch nothing.
- R9: A capture into B sets the request flag (control word bit 12). `irq_req` is high when the flag, the enable bit (bit 8) and a level (bits [2:0]) other than 7 are all present.
- R10: The flag is cleared only by a write to address 3 with bit 12 equal to 0, and is never cleared by hardware. A level of 7 holds `irq_req` low.
- R11: Every value of the direction field, mode bits [13:12], counts upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src | input | 8 | Candidate count ticks; line 1 is the prescaler underflow |
| cap_a_in | input | 1 | Asynchronous capture input for A |
| cap_b_in | input | 1 | Asynchronous capture input for B |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address (0 mode, 1 A, 2 B, 3 interrupt control) |
| bus_wdata | input | 16 | Write data |
| mode_q | output | 16 | Mode word |
| reg_a | output | 16 | Compare/capture register A |
| reg_b | output | 16 | Compare/capture register B |
| count | output | 16 | Counter value |
| sr_out | output | 1 | Set/reset flip-flop output |
| irq_flag | output | 1 | Capture-B request flag |
| irq_req | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with its default values: a 16-bit counter, eight tick lines and two synchronizer stages. At 16 bits, a full rollover needs only about 65 thousand cycles with the tick held high, so the 0xFFFF-to-zero wrap is exercised directly rather than through a narrowed counter. Two synchronizer stages give a fixed, known capture latency. That lets the bench freeze the count, pulse a capture input and compare A or B against an exactly predicted value.

// File: rtl/tm16_pkg.sv
package tm16_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } tm_state_e;

    // mode word bit positions
    localparam int B_EN   = 15;
    localparam int B_NLD  = 14;
    localparam int B_MDHI = 9;
    localparam int B_MDLO = 8;

    // interrupt control word bit positions
    localparam int B_IEN  = 8;
    localparam int B_FLAG = 12;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_A    = 2'd1;
    localparam logic [1:0] ADDR_B    = 2'd2;
    localparam logic [1:0] ADDR_IRQ  = 2'd3;

    localparam logic [1:0] MD_WRITABLE = 2'b00;
    localparam logic [1:0] MD_CAPTURE  = 2'b11;

    localparam logic [2:0] LVL_OFF = 3'd7;

endpackage

// File: rtl/tm16_edge_sync.sv
module tm16_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            last_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign rise = shift_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tm16_ctrl_fsm.sv
module tm16_ctrl_fsm
    import tm16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nld,
    input  logic en,
    input  logic tick,
    output logic cnt_en
);
    tm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (nld) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!nld)    state_d = ST_CLEAR;
                else if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!nld)     state_d = ST_CLEAR;
                else if (!en) state_d = ST_ARMED;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        cnt_en = (state_q == ST_RUN) && nld && en && tick;
    end
endmodule

// File: rtl/tm16_counter.sv
module tm16_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
    import tm16_pkg::*;
#(
    parameter int W           = 16,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int N_SRC      = 1 << SEL_W,
    localparam int N_CAP      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] tick_src,
    input  logic             cap_a_in,
    input  logic             cap_b_in,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     mode_q,
    output logic [W-1:0]     reg_a,
    output logic [W-1:0]     reg_b,
    output logic [W-1:0]     count,
    output logic             sr_out,
    output logic             irq_flag,
    output logic             irq_req
);
    logic             nld, en, tick, cnt_en, clr_cnt;
    logic [1:0]       md;
    logic [SEL_W-1:0] sel;
    logic [N_CAP-1:0] cap_raw, cap_rise;
    logic [2:0]       irq_lvl;
    logic             irq_en;
    logic             wr_mode, wr_a, wr_b, wr_irq, capturing;

    assign nld       = mode_q[B_NLD];
    assign en        = mode_q[B_EN];
    assign md        = mode_q[B_MDHI:B_MDLO];
    assign sel       = mode_q[SEL_W-1:0];
    assign tick      = tick_src[sel];
    assign clr_cnt   = ~nld;
    assign capturing = (md == MD_CAPTURE);

    assign wr_mode = bus_we && (bus_addr == ADDR_MODE);
    assign wr_a    = bus_we && (bus_addr == ADDR_A) && (md == MD_WRITABLE);
    assign wr_b    = bus_we && (bus_addr == ADDR_B) && (md == MD_WRITABLE);
    assign wr_irq  = bus_we && (bus_addr == ADDR_IRQ);

    assign cap_raw = {cap_b_in, cap_a_in};

    for (genvar g = 0; g < N_CAP; g++) begin : g_cap
        tm16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cap_raw[g]),
            .rise (cap_rise[g])
        );
    end

    tm16_ctrl_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .nld   (nld),
        .en    (en),
        .tick  (tick),
        .cnt_en(cnt_en)
    );

    tm16_counter #(.W(W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_cnt),
        .inc  (cnt_en),
        .cnt  (count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
        end else begin
            if (capturing && cap_rise[0]) reg_a <= count;
            else if (wr_a)                reg_a <= bus_wdata;
            if (capturing && cap_rise[1]) reg_b <= count;
            else if (wr_b)                reg_b <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sr_out <= 1'b0;
        else if (!nld)           sr_out <= 1'b0;
        else if (count == reg_b) sr_out <= 1'b0;
        else if (count == reg_a) sr_out <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_lvl  <= '0;
            irq_en   <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (wr_irq) begin
                irq_lvl <= bus_wdata[2:0];
                irq_en  <= bus_wdata[B_IEN];
                if (!bus_wdata[B_FLAG]) irq_flag <= 1'b0;
            end
            if (capturing && cap_rise[1]) irq_flag <= 1'b1;
        end
    end

    assign irq_req = irq_flag && irq_en && (irq_lvl != LVL_OFF);
endmodule

// File: rtl/tm16_checker.sv
module tm16_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] mode_q,
    input logic [W-1:0] count,
    input logic [W-1:0] reg_a,
    input logic         sr_out,
    input logic         cap_rise_a,
    input logic         cnt_en,
    input logic         irq_flag,
    input logic         bus_we,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata
);
    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[14] |=> (count == '0) && !sr_out); // R2

    AST_ARMED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[14] && !mode_q[15]) |=> $stable(count)); // R3

    AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (count == {W{1'b1}} && cnt_en) |=> (count == '0)); // R5

    AST_CAPTURE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[9:8] == 2'b11 && !cap_rise_a) |=> $stable(reg_a)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(bus_we && bus_addr == 2'd3 && !bus_wdata[12])) |=> irq_flag); // R10
endmodule

bind cap_timer16 tm16_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .count     (count),
    .reg_a     (reg_a),
    .sr_out    (sr_out),
    .cap_rise_a(cap_rise[0]),
    .cnt_en    (cnt_en),
    .irq_flag  (irq_flag),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/tb_cap_timer16.sv
module tb_cap_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tick_src = '0;
    logic        cap_a_in = 1'b0;
    logic        cap_b_in = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] mode_q, reg_a, reg_b, count;
    logic        sr_out, irq_flag, irq_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cap_timer16 dut (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src),
        .cap_a_in(cap_a_in), .cap_b_in(cap_b_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mode_q(mode_q), .reg_a(reg_a), .reg_b(reg_b), .count(count),
        .sr_out(sr_out), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input int line, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_src[line] = 1'b1;
            @(negedge clk); tick_src[line] = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic hold(input int n);
        @(negedge clk); tick_src[1] = 1'b1;
        repeat (n) @(negedge clk);
        tick_src[1] = 1'b0;
        @(negedge clk);
    endtask

    task automatic cap_pulse(input bit chan_b);
        @(negedge clk);
        if (chan_b) cap_b_in = 1'b1; else cap_a_in = 1'b1;
        repeat (2) @(negedge clk);
        cap_a_in = 1'b0; cap_b_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 mode", mode_q, 16'h0);
        check("R1 count", count, 16'h0);
        check("R1 a", reg_a, 16'h0);
        check("R1 b", reg_b, 16'h0);
        check("R1 flags", {13'b0, sr_out, irq_flag, irq_req}, 16'h0);
    endtask

    task automatic t_arm;
        pulse(1, 2);
        check("R2 ticks while cleared", count, 16'h0);
        wr(0, 16'h4001);
        pulse(1, 3);
        check("R3 armed holds", count, 16'h0);
    endtask

    task automatic t_regs_writable;
        wr(1, 16'h0003);
        wr(2, 16'h0006);
        check("R6 write a", reg_a, 16'h0003);
        check("R6 write b", reg_b, 16'h0006);
        cap_pulse(1'b1);
        check("R8 no capture outside mode", reg_b, 16'h0006);
        check("R9 no flag outside mode", {15'b0, irq_flag}, 16'h0);
    endtask

    task automatic t_run_compare;
        wr(0, 16'hC001);
        pulse(2, 4);
        check("R4 unselected line", count, 16'h0);
        pulse(1, 2);
        check("R4 selected line", count, 16'h2);
        check("R7 sr before A", {15'b0, sr_out}, 16'h0);
        pulse(1, 1);
        check("R7 sr set at A", {15'b0, sr_out}, 16'h1);
        pulse(1, 2);
        check("R7 sr held", {15'b0, sr_out}, 16'h1);
        pulse(1, 1);
        check("R7 count", count, 16'h6);
        check("R7 sr reset at B", {15'b0, sr_out}, 16'h0);
    endtask

    task automatic t_wrap;
        hold(65530);
        check("R5 wrap to zero", count, 16'h0);
        hold(1);
        check("R5 continues", count, 16'h1);
    endtask

    task automatic t_dir_and_clear;
        wr(0, 16'hE001);
        pulse(1, 3);
        check("R11 other direction code counts up", count, 16'h4);
        check("R7 sr set passing A", {15'b0, sr_out}, 16'h1);
        wr(0, 16'h2001);
        check("R2 count cleared", count, 16'h0);
        check("R2 sr cleared", {15'b0, sr_out}, 16'h0);
        pulse(1, 2);
        check("R2 hold while cleared", count, 16'h0);
    endtask

    task automatic t_capture_irq;
        wr(0, 16'hC301);
        pulse(1, 7);
        check("R8 count before capture", count, 16'h7);
        wr(1, 16'h1234);
        check("R6 write ignored in capture", reg_a, 16'h0003);
        cap_pulse(1'b0);
        check("R8 capture a", reg_a, 16'h0007);
        pulse(1, 2);
        cap_pulse(1'b1);
        check("R8 capture b", reg_b, 16'h0009);
        check("R9 flag set", {15'b0, irq_flag}, 16'h1);
        check("R9 no req while disabled", {15'b0, irq_req}, 16'h0);
        wr(3, 16'h1102);
        check("R9 req enabled", {15'b0, irq_req}, 16'h1);
        wr(3, 16'h1107);
        check("R10 level 7 blocks", {15'b0, irq_req}, 16'h0);
        check("R10 flag sticky", {15'b0, irq_flag}, 16'h1);
        wr(3, 16'h0102);
        check("R10 flag cleared", {15'b0, irq_flag}, 16'h0);
        check("R10 req after clear", {15'b0, irq_req}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_regs_writable();
        t_run_compare();
        t_wrap();
        t_dir_and_clear();
        t_capture_irq();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule